// File: doc/BRIEF.md
# Interrupt Line Configuration Window

This block holds one configuration word for each of 32 interrupt input lines, and presents all of them to software through two bus registers. Software writes an encoded line number into a pointer register. It then reads or writes a data port, and that access reaches the configuration word of the chosen line.

Each word keeps three live bits:
- a mask bit (bit 16),
- a level-versus-edge trigger flag (bit 15),
- an active-low polarity flag (bit 13).

All other bits are hardwired to zero. The block drives these three bits of every line out in parallel, as vectors for the downstream interrupt logic.

The pointer does not hold a plain line number. Bits 3..0 of the line sit at pointer bits 4..1, and bit 4 of the line sits at pointer bit 6. Pointer bits 0, 5 and 7 must be zero. Any other pointer value selects nothing.

The bus is a single-cycle bus. A write is taken on the rising clock edge while the write strobe is high. A read is combinational from the address and the stored state.

Top module: `redir_window`

## Requirements
- R1: While reset is asserted and right after it, every line's mask output is 1 and its trigger and polarity outputs are 0. The data port reads 0x0001_0000 for any line, and the pointer reads 0.
- R2: A write to the pointer address (offset 0x00) stores bus bits 7..0. A pointer read returns those 8 bits with bits 31..8 reading 0.
- R3: Line n is reached with pointer value ((n & 0xF) << 1) | ((n & 0x10) << 2).
- R4: A data-port write (offset 0x10) with a valid pointer changes only the pointed-to line's word. All other lines keep their values.
- R5: Only bits 16, 15 and 13 of a word can be set. Every other bit reads 0, whatever value was written.
- R6: If the pointer has bit 0, 5 or 7 set, data-port reads return 0 and data-port writes change no line.
- R7: A data-port read reflects the stored word in the same cycle. A write becomes visible only after the clock edge that takes it.
- R8: For each line n, line_mask[n], line_level[n] and line_pol[n] equal bits 16, 15 and 13 of that line's word.
- R9: Reading a word, changing one field and writing it back leaves the other fields of that word unchanged.
- R10: Writes to any address other than the two registers change no state, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| line_mask | output | 32 | Per-line mask, 1 = masked |
| line_level | output | 32 | Per-line trigger flag, 1 = level |
| line_pol | output | 32 | Per-line polarity flag, 1 = active low |

## Verification
Every one of the 32 lines is written through its encoded pointer with a pattern that depends on its index. This separates a wrong nibble placement from a correct one, because lines 0..15 and 16..31 then land on distinct words. All-ones data shows that unsupported bits are dropped. Pointers with bits 0, 5 or 7 set, and an unused bus offset, show that stray accesses leave the output vectors intact. A write observed before and after its edge separates the combinational read path from the registered update.

// File: rtl/redir_window.sv
module redir_window #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 5,
  parameter int SEL_OFS   = 0,
  parameter int WIN_OFS   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] line_mask,
  output logic [NUM_LINES-1:0] line_level,
  output logic [NUM_LINES-1:0] line_pol
);
  localparam int          MASK_BIT = 16;
  localparam int          TRIG_BIT = 15;
  localparam int          POL_BIT  = 13;
  localparam logic [31:0] SUP_BITS = (32'd1 << MASK_BIT) | (32'd1 << TRIG_BIT) | (32'd1 << POL_BIT);
  localparam logic [31:0] RST_WORD = 32'd1 << MASK_BIT;

  logic [7:0]  sel_q;
  logic [31:0] ent [NUM_LINES];

  wire [4:0] line_idx = {sel_q[6], sel_q[4:1]};
  wire       sel_ok   = !(sel_q[7] | sel_q[5] | sel_q[0]) && (32'(line_idx) < NUM_LINES);
  wire       hit_sel  = bus_addr == ADDR_W'(SEL_OFS);
  wire       hit_win  = bus_addr == ADDR_W'(WIN_OFS);
  wire       win_wr   = bus_wr && hit_win && sel_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                sel_q <= '0;
    else if (bus_wr && hit_sel) sel_q <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) ent[i] <= RST_WORD;
    end else if (win_wr) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (32'(line_idx) == i) ent[i] <= bus_wdata & SUP_BITS;
    end

  always_comb begin
    bus_rdata = '0;
    if (hit_sel)               bus_rdata = {24'd0, sel_q};
    else if (hit_win && sel_ok) bus_rdata = ent[line_idx];
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_out
    assign line_mask[g]  = ent[g][MASK_BIT];
    assign line_level[g] = ent[g][TRIG_BIT];
    assign line_pol[g]   = ent[g][POL_BIT];
  end
endmodule

// File: rtl/redir_window_chk.sv
module redir_window_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 5,
  parameter int SEL_OFS   = 0,
  parameter int WIN_OFS   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [7:0]           sel_q,
  input logic [NUM_LINES-1:0] line_mask,
  input logic [NUM_LINES-1:0] line_level,
  input logic [NUM_LINES-1:0] line_pol
);
  logic       at_win, bad_sel;
  logic [4:0] chk_idx;
  assign at_win  = bus_addr == ADDR_W'(WIN_OFS);
  assign bad_sel = (sel_q & 8'hA1) != 8'h00;
  assign chk_idx = {sel_q[6], sel_q[4:1]};

  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&line_mask && line_level == '0 && line_pol == '0)); // R1
  AST_UNSUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    at_win |-> (bus_rdata & 32'hFFFE_5FFF) == 32'd0); // R5
  AST_BADSEL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (at_win && bad_sel) |-> bus_rdata == 32'd0); // R6
  AST_BADSEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_win && bad_sel) |=> ($stable(line_mask) && $stable(line_level) && $stable(line_pol))); // R6
  AST_NO_WIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && at_win) |=> ($stable(line_mask) && $stable(line_level) && $stable(line_pol))); // R10
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_win && !bad_sel) |=>
      (line_mask[$past(chk_idx)] == $past(bus_wdata[16]) && line_level[$past(chk_idx)] == $past(bus_wdata[15]))); // R8
  AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(SEL_OFS)) |-> bus_rdata[31:8] == 24'd0); // R2
endmodule

bind redir_window redir_window_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .SEL_OFS(SEL_OFS), .WIN_OFS(WIN_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_q(sel_q),
  .line_mask(line_mask), .line_level(line_level), .line_pol(line_pol)
);

// File: tb/test_redir_window.sv
module test_redir_window;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0]  A_SEL = 5'h00;
  localparam logic [4:0]  A_WIN = 5'h10;
  localparam logic [31:0] SUP   = 32'h0001_A000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] line_mask, line_level, line_pol;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  redir_window i_redir_window (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_mask(line_mask), .line_level(line_level), .line_pol(line_pol)
  );

  function automatic logic [31:0] enc(int n);
    return 32'(((n & 15) << 1) | ((n & 16) << 2));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic check_lines(string req);
    logic [31:0] em, el, ep;
    for (int n = 0; n < 32; n++) begin
      em[n] = model[n][16]; el[n] = model[n][15]; ep[n] = model[n][13];
    end
    #1;
    check({req, " mask"},  line_mask,  em);
    check({req, " level"}, line_level, el);
    check({req, " pol"},   line_pol,   ep);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int n = 0; n < 32; n++) model[n] = 32'h0001_0000;
    check_lines("R1");
    bus_read(A_SEL, d);
    check("R1 pointer", d, 32'd0);
    bus_read(A_WIN, d);
    check("R1 word0", d, 32'h0001_0000);
  endtask

  task automatic t_pointer();
    logic [31:0] d;
    bus_write(A_SEL, 32'hFFFF_FF12);
    bus_read(A_SEL, d);
    check("R2 readback", d, 32'h0000_0012);
  endtask

  task automatic t_all_lines();
    logic [31:0] d, w;
    for (int n = 0; n < 32; n++) begin
      w = ((n % 3) == 0 ? 32'h0001_0000 : 32'h0) | (n[0] ? 32'h0000_8000 : 32'h0) |
          (n[1] ? 32'h0000_2000 : 32'h0);
      bus_write(A_SEL, enc(n));
      bus_write(A_WIN, w);
      model[n] = w;
    end
    check_lines("R3 R4 R8");
    for (int n = 0; n < 32; n++) begin
      bus_write(A_SEL, enc(n));
      bus_read(A_WIN, d);
      check($sformatf("R3 line%0d", n), d, model[n]);
    end
  endtask

  task automatic t_unsupported();
    logic [31:0] d;
    bus_write(A_SEL, enc(5));
    bus_write(A_WIN, 32'hFFFF_FFFF);
    model[5] = SUP;
    bus_read(A_WIN, d);
    check("R5 allones", d, SUP);
    check_lines("R5 R4");
  endtask

  task automatic t_rmw();
    logic [31:0] d;
    bus_write(A_SEL, enc(23));
    bus_write(A_WIN, 32'h0001_A000);
    bus_read(A_WIN, d);
    bus_write(A_WIN, d & ~32'h0001_0000);
    model[23] = 32'h0000_A000;
    bus_read(A_WIN, d);
    check("R9 kept", d, 32'h0000_A000);
    check_lines("R9");
  endtask

  task automatic t_badsel();
    logic [31:0] d;
    logic [31:0] bad [4] = '{32'h01, 32'h20, 32'h80, 32'h43};
    for (int k = 0; k < 4; k++) begin
      bus_write(A_SEL, bad[k]);
      bus_write(A_WIN, 32'h0000_0000);
      bus_read(A_WIN, d);
      check($sformatf("R6 read sel=%h", bad[k]), d, 32'd0);
    end
    check_lines("R6");
  endtask

  task automatic t_timing();
    bus_write(A_SEL, enc(9));
    @(negedge clk);
    bus_addr = A_WIN; bus_wr = 1'b1; bus_wdata = 32'h0000_2000;
    #1 check("R7 before edge", bus_rdata, model[9]);
    @(negedge clk);
    bus_wr = 1'b0;
    model[9] = 32'h0000_2000;
    #1 check("R7 after edge", bus_rdata, 32'h0000_2000);
  endtask

  task automatic t_other_addr();
    logic [31:0] d;
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_read(5'h08, d);
    check("R10 read", d, 32'd0);
    bus_read(A_SEL, d);
    check("R10 pointer", d, enc(9));
    check_lines("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_pointer();
    t_all_lines();
    t_unsupported();
    t_rmw();
    t_badsel();
    t_timing();
    t_other_addr();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule